// File: doc/BRIEF.md
# Keyed Flash Command Controller

This block sits between a simple register bus and an on-chip non-volatile array. Software loads a target address, a data word and, for configuration updates, a pending configuration value. It then launches one operation by writing the control register. That write must carry a 16-bit key in its upper half. The key is either the fixed constant 0xA442 or a key supplied on a port, and an input bit chooses between them. A write with a wrong key leaves the block exactly as it was.

Four operations are available: a single-word program, an erase of the page that holds the address, an erase of the whole main array, and a commit of the pending configuration value. Each one has its own bit in the control register. The bit is set when the operation is launched and reads 1 while it runs. It clears by itself when the array reports completion. Toward the array the block gives a one-cycle start pulse with an opcode, an address and a data word, and it waits for a one-cycle done pulse.

A keyed write that asks for more than one operation is refused and sets an error flag. While an operation is running, every write to the block is dropped.

Top module: `keyed_flash_cmd`

## Requirements
- R1: After reset every register reads 0, and fl_start, cmd_err and the array outputs are 0.
- R2: Bus offsets 0x0 (address, ADDR_W bits, zero-extended on read), 0x4 (data word) and 0xC (pending configuration value) are written by bus_wr and read back on bus_rdata. Reads are combinational from bus_addr.
- R3: A read of the control register at offset 0x8 returns 0 in bits 31:4. Bits 3:0 hold the operation bits: bit 0 word program, bit 1 page erase, bit 2 mass erase, bit 3 commit.
- R4: A control write whose bits 31:16 do not equal the expected key changes no register, starts nothing and leaves cmd_err unchanged.
- R5: With key_sel=0 the expected key is 0xA442. With key_sel=1 the expected key is prog_key.
- R6: A keyed control write with exactly one operation bit set, made while idle, sets that bit. In the next cycle it raises fl_start for exactly one cycle with fl_op = 0 (program), 1 (page erase), 2 (mass erase) or 3 (commit).
- R7: With fl_start, a program sends the address and data registers. A page erase sends the address with its low PAGE_W bits cleared and data 0. A mass erase sends address 0 and data 0. A commit sends the address register and the pending configuration value.
- R8: The running operation bit clears at the clock edge where fl_done is sampled high. Before that edge it reads 1; after it, it reads 0.
- R9: A keyed control write with bits 3:0 all zero changes nothing and leaves cmd_err unchanged.
- R10: A keyed control write made while idle with two or more operation bits set starts nothing, leaves the operation bits at 0 and sets cmd_err. The next accepted operation clears cmd_err.
- R11: While an operation bit is set, all bus writes are ignored (address, data, pending value and control), and no further fl_start is issued.
- R12: fl_done while idle changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| key_sel | input | 1 | 0: fixed key 0xA442, 1: prog_key |
| prog_key | input | 16 | Programmable key value |
| cmd_err | output | 1 | Multiple-operation rejection flag |
| fl_start | output | 1 | One-cycle start pulse to array |
| fl_op | output | 2 | Operation code |
| fl_addr | output | ADDR_W | Operation address |
| fl_data | output | 32 | Operation data |
| fl_done | input | 1 | One-cycle completion pulse from array |

## Verification
The hardest situation to reach is a bus write that lands while an operation is still running, because a normal array would finish before software tries again. The bench switches its array model from automatic to manual completion, launches a program, and then fires address, data and keyed control writes into the busy window. It checks the register readback and the absence of any extra start before it releases done by hand on a chosen cycle. The same manual mode pins down the exact edge at which the busy bit falls.

// File: rtl/kfc_pkg.sv
package kfc_pkg;
  localparam int BUS_W = 32;
  localparam int KEY_W = 16;
  localparam int CMD_W = 4;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] OFF_ADDR = 4'h0;
  localparam logic [REG_AW-1:0] OFF_DATA = 4'h4;
  localparam logic [REG_AW-1:0] OFF_CTRL = 4'h8;
  localparam logic [REG_AW-1:0] OFF_PEND = 4'hC;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_PAGE   = 2'd1,
    OP_MASS   = 2'd2,
    OP_COMMIT = 2'd3
  } kfc_op_e;
endpackage

// File: rtl/kfc_key_check.sv
module kfc_key_check
  import kfc_pkg::*;
#(
  parameter logic [KEY_W-1:0] FIXED_KEY = 16'hA442
) (
  input  logic [BUS_W-1:0] wdata,
  input  logic             key_sel,
  input  logic [KEY_W-1:0] prog_key,
  output logic             key_ok,
  output logic             single,
  output logic             multi
);
  logic [KEY_W-1:0] expect_key;
  logic [CMD_W-1:0] bits;

  always_comb begin
    expect_key = key_sel ? prog_key : FIXED_KEY;
    key_ok     = (wdata[BUS_W-1:BUS_W-KEY_W] == expect_key);
    bits       = wdata[CMD_W-1:0];
    single     = (bits != '0) && ((bits & (bits - 1'b1)) == '0);
    multi      = (bits != '0) && !single;
  end
endmodule

// File: rtl/kfc_regs.sv
module kfc_regs
  import kfc_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BUS_W-1:0]  data_q,
  output logic [BUS_W-1:0]  pend_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      pend_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == OFF_ADDR) addr_q <= bus_wdata[ADDR_W-1:0];
      if (bus_addr == OFF_DATA) data_q <= bus_wdata;
      if (bus_addr == OFF_PEND) pend_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/kfc_cmd.sv
module kfc_cmd
  import kfc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              key_ok,
  input  logic              single,
  input  logic              multi,
  input  logic [CMD_W-1:0]  req_bits,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [BUS_W-1:0]  data_q,
  input  logic [BUS_W-1:0]  pend_q,
  input  logic              fl_done,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              busy,
  output logic              err_q,
  output logic              start_q,
  output logic [1:0]        op_q,
  output logic [ADDR_W-1:0] faddr_q,
  output logic [BUS_W-1:0]  fdata_q
);
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic              accept, reject;
  kfc_op_e           nxt_op;
  logic [ADDR_W-1:0] nxt_addr;
  logic [BUS_W-1:0]  nxt_data;

  always_comb begin
    busy   = |cmd_q;
    accept = ctrl_wr && key_ok && !busy && single;
    reject = ctrl_wr && key_ok && !busy && multi;
    nxt_op   = OP_PROG;
    nxt_addr = addr_q;
    nxt_data = data_q;
    if (req_bits[1]) begin
      nxt_op   = OP_PAGE;
      nxt_addr = addr_q & PAGE_MASK;
      nxt_data = '0;
    end else if (req_bits[2]) begin
      nxt_op   = OP_MASS;
      nxt_addr = '0;
      nxt_data = '0;
    end else if (req_bits[3]) begin
      nxt_op   = OP_COMMIT;
      nxt_data = pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      op_q    <= '0;
      faddr_q <= '0;
      fdata_q <= '0;
    end else if (accept) begin
      cmd_q   <= req_bits;
      err_q   <= 1'b0;
      start_q <= 1'b1;
      op_q    <= nxt_op;
      faddr_q <= nxt_addr;
      fdata_q <= nxt_data;
    end else begin
      start_q <= 1'b0;
      if (reject) err_q <= 1'b1;
      if (busy && fl_done) cmd_q <= '0;
    end
  end
endmodule

// File: rtl/keyed_flash_cmd.sv
module keyed_flash_cmd
  import kfc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 10,
  parameter logic [15:0] FIXED_KEY = 16'hA442
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              key_sel,
  input  logic [15:0]       prog_key,
  output logic              cmd_err,
  output logic              fl_start,
  output logic [1:0]        fl_op,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [31:0]       fl_data,
  input  logic              fl_done
);
  logic              key_ok, single, multi, busy, ctrl_wr, data_wr;
  logic [CMD_W-1:0]  cmd_bits;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q, pend_q;

  assign ctrl_wr = bus_wr && (bus_addr == OFF_CTRL);
  assign data_wr = bus_wr && !busy;

  kfc_key_check #(.FIXED_KEY(FIXED_KEY)) u_key (
    .wdata(bus_wdata), .key_sel(key_sel), .prog_key(prog_key),
    .key_ok(key_ok), .single(single), .multi(multi)
  );

  kfc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ok(data_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .addr_q(addr_q), .data_q(data_q), .pend_q(pend_q)
  );

  kfc_cmd #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .key_ok(key_ok),
    .single(single), .multi(multi), .req_bits(bus_wdata[CMD_W-1:0]),
    .addr_q(addr_q), .data_q(data_q), .pend_q(pend_q), .fl_done(fl_done),
    .cmd_q(cmd_bits), .busy(busy), .err_q(cmd_err), .start_q(fl_start),
    .op_q(fl_op), .faddr_q(fl_addr), .fdata_q(fl_data)
  );

  always_comb begin
    case (bus_addr)
      OFF_ADDR: bus_rdata = {{(BUS_W-ADDR_W){1'b0}}, addr_q};
      OFF_DATA: bus_rdata = data_q;
      OFF_CTRL: bus_rdata = {{(BUS_W-CMD_W){1'b0}}, cmd_bits};
      OFF_PEND: bus_rdata = pend_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_flash_cmd_chk.sv
module keyed_flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fl_start,
  input logic       fl_done,
  input logic       cmd_err,
  input logic [3:0] busy_bits
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> !fl_start); // R6
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |-> ($past(busy_bits) == 4'd0 && $countones(busy_bits) == 1)); // R11
  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_bits)); // R10
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_bits != 4'd0 && fl_done) |=> busy_bits == 4'd0); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_bits != 4'd0 && !fl_done) |=> $stable(busy_bits)); // R11
  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_err) |-> (!fl_start && busy_bits == 4'd0)); // R10
endmodule

bind keyed_flash_cmd keyed_flash_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fl_start(fl_start), .fl_done(fl_done),
  .cmd_err(cmd_err), .busy_bits(cmd_bits)
);

// File: tb/keyed_flash_cmd_bench.sv
module keyed_flash_cmd_bench;
  localparam int ADDR_W = 18;
  logic clk = 0, rst_n = 0, bus_wr = 0, key_sel = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, fl_data;
  logic [15:0] prog_key = 16'h5A5A;
  logic cmd_err, fl_start, fl_done;
  logic [1:0] fl_op;
  logic [ADDR_W-1:0] fl_addr;
  logic auto_resp = 1, auto_done = 0, man_done = 0;
  int lat_cnt = 0, n_chk = 0, n_fail = 0;
  logic [51:0] exp_q[$];

  assign fl_done = auto_done | man_done;
  always #5 clk = ~clk;

  keyed_flash_cmd u_keyed_flash_cmd (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .key_sel(key_sel),
    .prog_key(prog_key), .cmd_err(cmd_err), .fl_start(fl_start),
    .fl_op(fl_op), .fl_addr(fl_addr), .fl_data(fl_data), .fl_done(fl_done)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected starts and compare
  always @(negedge clk) begin
    if (rst_n && fl_start) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R11 actual=unexpected start op=%0d expected=none", fl_op);
      end else begin
        logic [51:0] e;
        e = exp_q.pop_front();
        if ({fl_op, fl_addr, fl_data} !== e) begin
          n_fail++;
          $display("FAIL R7 actual=%h expected=%h", {fl_op, fl_addr, fl_data}, e);
        end
      end
    end
  end

  // automatic array responder
  always @(negedge clk) begin
    auto_done = 0;
    if (auto_resp && fl_start) lat_cnt = 4;
    else if (lat_cnt != 0) begin
      lat_cnt--;
      if (lat_cnt == 0) auto_done = 1;
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle_wait();
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); rd(4'h8, v);
      if (v == 0) break;
    end
  endtask

  task automatic cmd(logic [15:0] key, logic [3:0] bits, logic [51:0] exp, bit expect_start);
    if (expect_start) exp_q.push_back(exp);
    wr(4'h8, {key, 12'h0, bits});
  endtask

  initial begin
    int wd = 0;
    while (wd < 20000) begin @(posedge clk); wd++; end
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'h0, v); chk("R1 addr", v, 0);
    rd(4'h4, v); chk("R1 data", v, 0);
    rd(4'h8, v); chk("R1 ctrl", v, 0);
    rd(4'hC, v); chk("R1 pend", v, 0);
    chk("R1 start/err", {fl_start, cmd_err}, 0);

    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R2 addr width", v, 32'h3FFFF);
    wr(4'h0, 32'h0001_2345); rd(4'h0, v); chk("R2 addr", v, 32'h12345);
    wr(4'h4, 32'hCAFE_F00D); rd(4'h4, v); chk("R2 data", v, 32'hCAFE_F00D);
    wr(4'hC, 32'h0BAD_BEEF); rd(4'hC, v); chk("R2 pend", v, 32'h0BAD_BEEF);

    // R4 wrong key
    cmd(16'hA443, 4'h1, 0, 0);
    rd(4'h8, v); chk("R4 wrong key ctrl", v, 0);
    chk("R4 wrong key err", cmd_err, 0);
    repeat (3) @(negedge clk);

    // R6 program with fixed key; R3 key field reads 0
    cmd(16'hA442, 4'h1, {2'd0, 18'h12345, 32'hCAFE_F00D}, 1);
    rd(4'h8, v); chk("R3/R6 ctrl busy bit0", v, 32'h1);
    idle_wait(); rd(4'h8, v); chk("R8 cleared after done", v, 0);

    // R7 page erase, mass erase, commit
    cmd(16'hA442, 4'h2, {2'd1, 18'h12000, 32'h0}, 1);
    rd(4'h8, v); chk("R3 page bit", v, 32'h2);
    idle_wait();
    cmd(16'hA442, 4'h4, {2'd2, 18'h0, 32'h0}, 1);
    rd(4'h8, v); chk("R3 mass bit", v, 32'h4);
    idle_wait();
    cmd(16'hA442, 4'h8, {2'd3, 18'h12345, 32'h0BAD_BEEF}, 1);
    rd(4'h8, v); chk("R3 commit bit", v, 32'h8);
    idle_wait();

    // R5 programmable key
    key_sel = 1;
    cmd(16'hA442, 4'h1, 0, 0);
    rd(4'h8, v); chk("R5 fixed key refused", v, 0);
    cmd(16'h5A5A, 4'h1, {2'd0, 18'h12345, 32'hCAFE_F00D}, 1);
    rd(4'h8, v); chk("R5 prog key accepted", v, 32'h1);
    idle_wait();
    key_sel = 0;

    // R9 zero bits
    cmd(16'hA442, 4'h0, 0, 0);
    rd(4'h8, v); chk("R9 ctrl", v, 0); chk("R9 err", cmd_err, 0);

    // R10 multiple bits
    cmd(16'hA442, 4'h3, 0, 0);
    rd(4'h8, v); chk("R10 ctrl", v, 0); chk("R10 err set", cmd_err, 1);
    cmd(16'hA442, 4'h4, {2'd2, 18'h0, 32'h0}, 1);
    chk("R10 err cleared", cmd_err, 0);
    idle_wait();

    // R11 busy window with manual done; R8 exact edge
    auto_resp = 0;
    cmd(16'hA442, 4'h1, {2'd0, 18'h12345, 32'hCAFE_F00D}, 1);
    wr(4'h0, 32'h0000_0777);
    wr(4'h4, 32'h1111_1111);
    wr(4'hC, 32'h2222_2222);
    wr(4'h8, {16'hA442, 12'h0, 4'h4});
    wr(4'h8, {16'hA442, 12'h0, 4'h3});
    rd(4'h0, v); chk("R11 addr held", v, 32'h12345);
    rd(4'h4, v); chk("R11 data held", v, 32'hCAFE_F00D);
    rd(4'hC, v); chk("R11 pend held", v, 32'h0BAD_BEEF);
    rd(4'h8, v); chk("R11 ctrl held", v, 32'h1);
    chk("R11 no err", cmd_err, 0);
    @(negedge clk); man_done = 1;
    rd(4'h8, v); chk("R8 before edge", v, 32'h1);
    @(negedge clk); man_done = 0;
    rd(4'h8, v); chk("R8 after edge", v, 0);

    // R12 done while idle
    @(negedge clk); man_done = 1;
    @(negedge clk); man_done = 0;
    rd(4'h8, v); chk("R12 ctrl", v, 0);
    rd(4'h0, v); chk("R12 addr", v, 32'h12345);
    chk("R12 err", cmd_err, 0);

    repeat (4) @(negedge clk);
    chk("R6 all starts seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule